// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Add Unit

This unit evaluates one of four signed fused multiply-add forms on three IEEE 754 binary16 operands. The product and the sum are formed exactly, and the result is rounded only once. The three sources come from wider floating-point register values. In those values a binary16 number sits in the low 16 bits, and every bit above it is one (NaN-boxed). The result goes back in the same boxed form, together with five exception flags. The surrounding pipeline ORs those flags into its accrued-flag state.

Each operation starts with a one-cycle `start_i` strobe. The operation code and a 3-bit rounding field come with it. A rounding field of 7 selects the dynamic mode supplied on `frm_i`. One clock later the unit raises either `valid_o`, with the result and flags, or `rm_bad_o`, when the resolved rounding mode is illegal. A new operation may start on every cycle.

Top module: `half_fma`

## Requirements
- R1: The `op_i` code picks the signed form: 0 gives a*b+c, 1 gives a*b-c, 2 gives -(a*b)-c, and 3 gives -(a*b)+c. Negating the product flips the sign of the product only; no rounding happens before the final sum.
- R2: Bits FLEN-1..16 of `res_o` are all ones whenever `valid_o` is high. A source whose bits above bit 15 are not all ones is read as the quiet NaN 0x7E00, and reading it that way raises no flag.
- R3: When `rm_i` is 7, the unit rounds with the mode on `frm_i`. When `rm_i` is 0..4, it rounds with `rm_i`.
- R4: The exact value of ±(a*b)±c is rounded once to binary16. Mode 0 is nearest with ties to even, 1 is toward zero, 2 is toward minus infinity, 3 is toward plus infinity, and 4 is nearest with ties away from zero. Flag bits are invalid=4, divide-by-zero=3, overflow=2, underflow=1, inexact=0, and inexact (bit 0) is set for any rounded result that differs from the exact value.
- R5: If one multiplicand is infinite and the other is zero, the result is 0x7E00 with invalid (bit 4) set. This holds even when c is a quiet NaN.
- R6: If the signed product and the signed addend are infinities of opposite sign, the result is 0x7E00 with invalid (bit 4) set. The signed addend is c for codes 0 and 3 and -c for codes 1 and 2.
- R7: A signaling NaN (exponent all ones, fraction MSB 0, fraction nonzero) in any operand position sets invalid (bit 4). Any NaN result is 0x7E00. A quiet NaN input alone sets no flag.
- R8: Subnormal results are rounded at 2^-24. Underflow (bit 1) is set when the result is inexact and tiny, where tiny means the magnitude, rounded to 11 significant bits with an unbounded exponent, is below 2^-14.
- R9: A finite result that rounds to 2^16 or beyond sets overflow and inexact (bits 2 and 0). It returns infinity in modes 0 and 4, and the largest finite value 0x7BFF (with the result's sign) in mode 1. Mode 2 gives infinity when negative and 0x7BFF when positive. Mode 3 gives the reverse.
- R10: An exact zero sum of opposite-signed terms is +0, except in mode 2 where it is -0. The sum of two like-signed zeros keeps their sign.
- R11: If the resolved mode is 5, 6 or 7, `rm_bad_o` pulses one cycle after `start_i`, `valid_o` stays low, and `res_o` keeps its previous value.
- R12: `valid_o` pulses exactly one cycle after each accepted `start_i` and is low otherwise. Divide-by-zero (bit 3) is never set. After reset, `valid_o` and `rm_bad_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch one operation this cycle |
| op_i | input | 2 | Signed-form select (R1 encoding) |
| rm_i | input | 3 | Rounding field of the instruction, 7 = dynamic |
| frm_i | input | 3 | Dynamic rounding mode from the control register |
| src_a_i | input | FLEN | Boxed multiplicand a |
| src_b_i | input | FLEN | Boxed multiplicand b |
| src_c_i | input | FLEN | Boxed addend c |
| res_o | output | FLEN | Boxed binary16 result |
| valid_o | output | 1 | Result and flags valid |
| flags_o | output | 5 | Exception flags {NV,DZ,OF,UF,NX} |
| rm_bad_o | output | 1 | Resolved rounding mode illegal, nothing committed |

## Verification
The bench targets exact cancellation, where a rounded product would leave a wrong residue or a zero with the wrong sign. It also targets ties at the rounding point, where a design with a sticky or parity error picks the wrong neighbour. At the subnormal/normal border, tininess judged before rounding would raise underflow on results that round up to 2^-14. Overflow in each direction and mode catches a saturation table with swapped signs. The infinity-times-zero and opposite-infinity cases, each with a quiet NaN addend, catch a design that lets the NaN path hide the invalid flag. Badly boxed sources and illegal dynamic modes check that nothing is written and nothing leaks out.

// File: rtl/half_fma.sv
module half_fma #(
  parameter int FLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [2:0]      rm_i,
  input  logic [2:0]      frm_i,
  input  logic [FLEN-1:0] src_a_i,
  input  logic [FLEN-1:0] src_b_i,
  input  logic [FLEN-1:0] src_c_i,
  output logic [FLEN-1:0] res_o,
  output logic            valid_o,
  output logic [4:0]      flags_o,
  output logic            rm_bad_o
);
  localparam int HW = 16;
  localparam int BOXW = FLEN - HW;
  localparam int AW = 82;
  localparam logic [15:0] QNAN = 16'h7E00;

  function automatic logic [15:0] unbox(input logic [FLEN-1:0] r);
    return (&r[FLEN-1:HW]) ? r[HW-1:0] : QNAN;
  endfunction

  function automatic int eadj(input logic [15:0] x);
    return (x[14:10] == 5'd0) ? 1 : int'(x[14:10]);
  endfunction

  function automatic logic rinc(input logic [2:0] m, input logic s, input logic l,
                                input logic g, input logic t);
    case (m)
      3'd0:    return g & (t | l);
      3'd2:    return s & (g | t);
      3'd3:    return ~s & (g | t);
      3'd4:    return g;
      default: return 1'b0;
    endcase
  endfunction

  logic [15:0] h [3];
  assign h[0] = unbox(src_a_i);
  assign h[1] = unbox(src_b_i);
  assign h[2] = unbox(src_c_i);

  logic [2:0] nan, snan, inf;
  logic [1:0] zero;
  for (genvar i = 0; i < 3; i++) begin : g_cls
    assign nan[i]  = (&h[i][14:10]) & (|h[i][9:0]);
    assign snan[i] = nan[i] & ~h[i][9];
    assign inf[i]  = (&h[i][14:10]) & ~(|h[i][9:0]);
  end
  assign zero[0] = ~(|h[0][14:0]);
  assign zero[1] = ~(|h[1][14:0]);

  logic [2:0] rm_eff;
  logic       rm_ok;
  assign rm_eff = (rm_i == 3'd7) ? frm_i : rm_i;
  assign rm_ok  = rm_eff <= 3'd4;

  logic sp, sc, inv_mul, pinf, inv_add;
  assign sp      = h[0][15] ^ h[1][15] ^ op_i[1];
  assign sc      = h[2][15] ^ op_i[0] ^ op_i[1];
  assign inv_mul = (inf[0] & zero[1]) | (zero[0] & inf[1]);
  assign pinf    = (inf[0] | inf[1]) & ~inv_mul & ~nan[0] & ~nan[1];
  assign inv_add = pinf & inf[2] & (sp ^ sc);

  logic [21:0]   prod;
  logic [AW-1:0] pfix, cfix, mag, lowmask;
  logic          sgn, g, st, inc, inc_u, tiny, ofl, ovinf;
  logic [6:0]    p, lsb;
  logic [16:0]   enc;
  logic [15:0]   res_d;
  logic [4:0]    flg_d;

  always_comb begin
    prod = 22'({|h[0][14:10], h[0][9:0]}) * 22'({|h[1][14:10], h[1][9:0]});
    pfix = AW'(prod) << (eadj(h[0]) + eadj(h[1]) - 2);
    cfix = AW'({|h[2][14:10], h[2][9:0]}) << (eadj(h[2]) + 23);
    if (sp == sc) begin
      mag = pfix + cfix;
      sgn = sp;
    end else if (pfix >= cfix) begin
      mag = pfix - cfix;
      sgn = sp;
    end else begin
      mag = cfix - pfix;
      sgn = sc;
    end
    p = 7'd0;
    for (int i = 0; i < AW; i++) if (mag[i]) p = 7'(i);
    lsb     = (p >= 7'd34) ? p - 7'd10 : 7'd24;
    g       = mag[lsb - 7'd1];
    lowmask = (AW'(1) << (lsb - 7'd1)) - AW'(1);
    st      = |(mag & lowmask);
    inc     = rinc(rm_eff, sgn, mag[lsb], g, st);
    enc     = (17'(lsb - 7'd24) << 10) + 17'(mag >> lsb) + 17'(inc);
    inc_u   = rinc(rm_eff, sgn, mag[23], mag[22], |mag[21:0]);
    tiny    = (p < 7'd33) || ((p == 7'd33) && !((&mag[33:23]) && inc_u));
    ofl     = enc >= 17'h7C00;
    ovinf   = (rm_eff == 3'd0) || (rm_eff == 3'd4) ||
              ((rm_eff == 3'd2) && sgn) || ((rm_eff == 3'd3) && !sgn);

    flg_d = 5'b0;
    if ((|nan) | inv_mul | inv_add) begin
      res_d    = QNAN;
      flg_d[4] = (|snan) | inv_mul | inv_add;
    end else if (pinf) begin
      res_d = {sp, 15'h7C00};
    end else if (inf[2]) begin
      res_d = {sc, 15'h7C00};
    end else if (mag == '0) begin
      res_d = {(sp == sc) ? sp : (rm_eff == 3'd2), 15'h0};
    end else if (ofl) begin
      res_d = {sgn, ovinf ? 15'h7C00 : 15'h7BFF};
      flg_d = 5'b00101;
    end else begin
      res_d    = {sgn, enc[14:0]};
      flg_d[0] = g | st;
      flg_d[1] = tiny & (g | st);
    end
  end

  logic [15:0] res_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      rm_bad_o <= 1'b0;
      res_q    <= 16'h0;
      flags_o  <= 5'b0;
    end else begin
      valid_o  <= start_i & rm_ok;
      rm_bad_o <= start_i & ~rm_ok;
      if (start_i && rm_ok) begin
        res_q   <= res_d;
        flags_o <= flg_d;
      end
    end
  end

  assign res_o = {{BOXW{1'b1}}, res_q};
endmodule

// File: rtl/half_fma_chk.sv
module half_fma_chk #(
  parameter int FLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [2:0]      rm_i,
  input logic [2:0]      frm_i,
  input logic [FLEN-1:0] res_o,
  input logic            valid_o,
  input logic [4:0]      flags_o,
  input logic            rm_bad_o
);
  logic [2:0] rsel;
  assign rsel = (rm_i == 3'd7) ? frm_i : rm_i;

  // R12
  start_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (rsel <= 3'd4) |=> valid_o && !rm_bad_o);

  // R11
  bad_rm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (rsel > 3'd4) |=> rm_bad_o && !valid_o && $stable(res_o));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o && !rm_bad_o);

  // R12
  no_dz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !flags_o[3]);

  // R2
  boxed_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> &res_o[FLEN-1:16]);

  // R7
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && (&res_o[14:10]) && (|res_o[9:0]) |-> res_o[15:0] == 16'h7E00);

  // R9
  of_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && flags_o[2] |-> flags_o[0] && (res_o[14:10] >= 5'd30));

  // R8
  uf_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && flags_o[1] |-> flags_o[0]);
endmodule

bind half_fma half_fma_chk #(.FLEN(FLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rm_i(rm_i), .frm_i(frm_i),
  .res_o(res_o), .valid_o(valid_o), .flags_o(flags_o), .rm_bad_o(rm_bad_o)
);

// File: tb/half_fma_tb_top.sv
module half_fma_tb_top;
  localparam int FLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [2:0] rm_i = '0, frm_i = '0;
  logic [FLEN-1:0] src_a_i = '0, src_b_i = '0, src_c_i = '0;
  logic [FLEN-1:0] res_o;
  logic valid_o, rm_bad_o;
  logic [4:0] flags_o;

  always #5ns clk = ~clk;

  half_fma #(.FLEN(FLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .rm_i(rm_i),
    .frm_i(frm_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .src_c_i(src_c_i),
    .res_o(res_o), .valid_o(valid_o), .flags_o(flags_o), .rm_bad_o(rm_bad_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  string cur_tag = "R12", e_tag = "R12";
  logic e_valid = 1'b0, e_bad = 1'b0;
  logic [15:0] e_res = '0;
  logic [4:0] e_flg = '0;
  logic [FLEN-1:0] last_res = {{(FLEN-16){1'b1}}, 16'h0};

  function automatic logic [FLEN-1:0] bx(input logic [15:0] v);
    return {{(FLEN-16){1'b1}}, v};
  endfunction

  function automatic bit f_nan(input logic [15:0] v);  return v[14:10] == 5'h1f && v[9:0] != 0; endfunction
  function automatic bit f_snan(input logic [15:0] v); return f_nan(v) && !v[9]; endfunction
  function automatic bit f_inf(input logic [15:0] v);  return v[14:0] == 15'h7C00; endfunction
  function automatic bit f_zero(input logic [15:0] v); return v[14:0] == 15'h0; endfunction
  function automatic int f_man(input logic [15:0] v);  return (v[14:10] == 0) ? int'(v[9:0]) : 1024 + int'(v[9:0]); endfunction
  function automatic int f_exp(input logic [15:0] v);  return (v[14:10] == 0) ? -24 : int'(v[14:10]) - 25; endfunction

  function automatic bit rdir(input logic [2:0] rm, input bit s, input bit odd,
                              input logic [127:0] rem, input logic [127:0] half);
    case (rm)
      3'd0: return rem > half || (rem == half && odd);
      3'd2: return s && rem != 0;
      3'd3: return !s && rem != 0;
      3'd4: return rem >= half;
      default: return 1'b0;
    endcase
  endfunction

  function automatic void ref_fma(input logic [FLEN-1:0] ra, rb, rc, input logic [1:0] op,
                                  input logic [2:0] rm, output logic [15:0] r, output logic [4:0] fl);
    logic [15:0] a, b, c;
    logic signed [127:0] tp, tc, tot;
    logic [127:0] m, q, rem, half, qu, remu;
    bit s_p, s_c, sg, nx, tiny, carry, pinf;
    int k, cut, cu;
    a = (&ra[FLEN-1:16]) ? ra[15:0] : 16'h7E00;
    b = (&rb[FLEN-1:16]) ? rb[15:0] : 16'h7E00;
    c = (&rc[FLEN-1:16]) ? rc[15:0] : 16'h7E00;
    s_p = a[15] ^ b[15] ^ (op >= 2);
    s_c = c[15] ^ (op == 1 || op == 2);
    fl = 5'b0;
    if ((f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b))) begin
      r = 16'h7E00; fl = 5'b10000; return;
    end
    if (f_nan(a) || f_nan(b) || f_nan(c)) begin
      r = 16'h7E00;
      if (f_snan(a) || f_snan(b) || f_snan(c)) fl = 5'b10000;
      return;
    end
    pinf = f_inf(a) || f_inf(b);
    if (pinf && f_inf(c) && s_p != s_c) begin r = 16'h7E00; fl = 5'b10000; return; end
    if (pinf) begin r = {s_p, 15'h7C00}; return; end
    if (f_inf(c)) begin r = {s_c, 15'h7C00}; return; end
    tp = 128'(f_man(a) * f_man(b));
    tp = tp << (f_exp(a) + f_exp(b) + 48);
    tc = 128'(f_man(c));
    tc = tc << (f_exp(c) + 48);
    if (s_p) tp = -tp;
    if (s_c) tc = -tc;
    tot = tp + tc;
    if (tot == 0) begin
      r = {(s_p == s_c) ? s_p : (rm == 3'd2), 15'h0};
      return;
    end
    sg = tot[127];
    m = sg ? 128'(-tot) : 128'(tot);
    k = 0;
    for (int i = 0; i < 128; i++) if (m[i]) k = i;
    cut = (k - 48 >= -14) ? k - 10 : 24;
    q = m >> cut;
    rem = m - (q << cut);
    half = 128'(1) << (cut - 1);
    q = q + 128'(rdir(rm, sg, q[0], rem, half));
    if (q == 2048) begin q = 1024; cut++; end
    nx = rem != 0;
    tiny = 1'b0;
    if (k - 48 < -14) begin
      carry = 1'b0;
      cu = k - 10;
      if (cu > 0) begin
        qu = m >> cu;
        remu = m - (qu << cu);
        if (qu + 128'(rdir(rm, sg, qu[0], remu, 128'(1) << (cu - 1))) == 2048) carry = 1'b1;
      end
      tiny = (k - 48 + int'(carry)) < -14;
    end
    if (q >= 1024 && cut - 23 >= 31) begin
      fl = 5'b00101;
      if (rm == 0 || rm == 4 || (rm == 2 && sg) || (rm == 3 && !sg)) r = {sg, 15'h7C00};
      else r = {sg, 15'h7BFF};
      return;
    end
    if (q >= 1024) r = {sg, 5'(cut - 23), q[9:0]};
    else r = {sg, 5'b0, q[9:0]};
    fl = {3'b0, tiny && nx, nx};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [FLEN-1:0] act, input logic [FLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [2:0] rr;
    cyc++;
    if (!rst_n) begin
      e_valid = 1'b0; e_bad = 1'b0; e_tag = "R12";
    end else begin
      rr = (rm_i == 3'd7) ? frm_i : rm_i;
      e_valid = start_i && rr <= 3'd4;
      e_bad = start_i && rr > 3'd4;
      e_tag = start_i ? cur_tag : "R12";
      if (e_valid) ref_fma(src_a_i, src_b_i, src_c_i, op_i, rr, e_res, e_flg);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R12 watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    check(valid_o === e_valid, e_tag, "valid_o", FLEN'(valid_o), FLEN'(e_valid));
    check(rm_bad_o === e_bad, e_tag, "rm_bad_o", FLEN'(rm_bad_o), FLEN'(e_bad));
    if (rst_n && e_valid) begin
      check(res_o === bx(e_res), e_tag, "res_o", res_o, bx(e_res));
      check(flags_o === e_flg, e_tag, "flags_o", FLEN'(flags_o), FLEN'(e_flg));
      last_res = bx(e_res);
    end
    if (rst_n && e_bad) check(res_o === last_res, "R11", "res_o held", res_o, last_res);
  end

  task automatic send(input logic [FLEN-1:0] a, b, c, input logic [1:0] op,
                      input logic [2:0] rm, input logic [2:0] frm, input string tag);
    @(negedge clk);
    src_a_i = a; src_b_i = b; src_c_i = c;
    op_i = op; rm_i = rm; frm_i = frm; start_i = 1'b1; cur_tag = tag;
  endtask

  task automatic sendh(input logic [15:0] a, b, c, input logic [1:0] op,
                       input logic [2:0] rm, input string tag);
    send(bx(a), bx(b), bx(c), op, rm, 3'd0, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    start_i = 1'b0;
  endtask

  function automatic logic [15:0] rhalf();
    int sel = $urandom_range(0, 11);
    logic s = 1'($urandom);
    case (sel)
      0: return {s, 5'h1f, 1'b1, 9'($urandom)};
      1: return {s, 5'h1f, 1'b0, 9'($urandom_range(1, 511))};
      2: return {s, 15'h7C00};
      3: return {s, 15'h0};
      4: return {s, 5'h0, 10'($urandom)};
      5: return {s, 5'($urandom_range(12, 17)), 10'($urandom)};
      6: return {s, 5'($urandom_range(1, 4)), 10'($urandom)};
      7: return {s, 5'($urandom_range(27, 30)), 10'($urandom)};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state observed on the monitor's first compare
    idle();
    // R1: four signed forms, 1*1 with c=1 and 2*3 with c=0.5
    for (int o = 0; o < 4; o++) sendh(16'h3C00, 16'h3C00, 16'h3C00, 2'(o), 3'd0, "R1");
    for (int o = 0; o < 4; o++) sendh(16'h4000, 16'h4200, 16'h3800, 2'(o), 3'd0, "R1");
    // R10: exact cancellation and zero sign rules
    sendh(16'h3C00, 16'h3C00, 16'h3C00, 2'd1, 3'd0, "R10");
    sendh(16'h3C00, 16'h3C00, 16'h3C00, 2'd1, 3'd2, "R10");
    sendh(16'h8000, 16'h3C00, 16'h8000, 2'd0, 3'd0, "R10");
    sendh(16'h0000, 16'h3C00, 16'h8000, 2'd0, 3'd2, "R10");
    // R4: ties and inexact products in every mode
    for (int m = 0; m < 5; m++) sendh(16'h3C00, 16'h3C00, 16'h1000, 2'd0, 3'(m), "R4");
    for (int m = 0; m < 5; m++) sendh(16'h3C01, 16'h3C01, 16'h0000, 2'd2, 3'(m), "R4");
    for (int m = 0; m < 5; m++) sendh(16'h3C01, 16'h3C01, 16'h3C00, 2'd1, 3'(m), "R4");
    // R3: dynamic mode
    for (int m = 0; m < 5; m++) send(bx(16'h3C01), bx(16'h3C01), bx(16'h0), 2'd0, 3'd7, 3'(m), "R3");
    // R5: infinity times zero, with quiet NaN addend too
    sendh(16'h7C00, 16'h0000, 16'h3C00, 2'd0, 3'd0, "R5");
    sendh(16'h8000, 16'hFC00, 16'h7E00, 2'd3, 3'd0, "R5");
    // R6: opposite-signed infinities after the sign fold
    sendh(16'h7C00, 16'h3C00, 16'h7C00, 2'd1, 3'd0, "R6");
    sendh(16'h7C00, 16'h3C00, 16'hFC00, 2'd0, 3'd0, "R6");
    sendh(16'h7C00, 16'h3C00, 16'h7C00, 2'd0, 3'd0, "R6");
    sendh(16'h7C00, 16'h3C00, 16'h7C00, 2'd3, 3'd0, "R6");
    // R7: signaling NaN in each slot, quiet NaN alone
    sendh(16'h7C01, 16'h3C00, 16'h3C00, 2'd0, 3'd0, "R7");
    sendh(16'h3C00, 16'hFD00, 16'h3C00, 2'd0, 3'd0, "R7");
    sendh(16'h3C00, 16'h3C00, 16'h7C10, 2'd0, 3'd0, "R7");
    sendh(16'hFE55, 16'h3C00, 16'h3C00, 2'd0, 3'd0, "R7");
    // R2: badly boxed source reads as quiet NaN
    send({48'h0, 16'h3C00}, bx(16'h3C00), bx(16'h3C00), 2'd0, 3'd0, 3'd0, "R2");
    send(bx(16'h3C00), bx(16'h3C00), {48'h7FFF_FFFF_FFFF, 16'h3C00}, 2'd0, 3'd0, 3'd0, "R2");
    // R8: subnormal results and tininess after rounding
    for (int m = 0; m < 5; m++) sendh(16'h0C00, 16'h0C00, 16'h0000, 2'd0, 3'(m), "R8");
    for (int m = 0; m < 5; m++) sendh(16'h0C00, 16'h0800, 16'h0000, 2'd0, 3'(m), "R8");
    for (int m = 0; m < 5; m++) sendh(16'h03FF, 16'h3C01, 16'h0000, 2'd0, 3'(m), "R8");
    for (int m = 0; m < 5; m++) sendh(16'h03FF, 16'h3BFF, 16'h0001, 2'd0, 3'(m), "R8");
    // R9: overflow in both directions, all modes
    for (int m = 0; m < 5; m++) sendh(16'h7BFF, 16'h4000, 16'h0000, 2'd0, 3'(m), "R9");
    for (int m = 0; m < 5; m++) sendh(16'h7BFF, 16'h4000, 16'h0000, 2'd2, 3'(m), "R9");
    for (int m = 0; m < 5; m++) sendh(16'h7BFF, 16'h3C00, 16'h5000, 2'd0, 3'(m), "R9");
    // R11: illegal modes, static and dynamic
    sendh(16'h3C00, 16'h4000, 16'h3C00, 2'd0, 3'd5, "R11");
    sendh(16'h3C00, 16'h4000, 16'h3C00, 2'd0, 3'd6, "R11");
    send(bx(16'h3C00), bx(16'h4000), bx(16'h3C00), 2'd0, 3'd7, 3'd5, "R11");
    send(bx(16'h3C00), bx(16'h4000), bx(16'h3C00), 2'd0, 3'd7, 3'd7, "R11");
    idle(); idle();
    // R12: random traffic with gaps; R4 covers the arithmetic
    for (int n = 0; n < 4000; n++) begin
      logic [FLEN-1:0] a, b, c;
      int r = $urandom_range(0, 9);
      logic [2:0] rm, frm;
      a = bx(rhalf()); b = bx(rhalf()); c = bx(rhalf());
      if ($urandom_range(0, 29) == 0) a[FLEN-1:16] = (FLEN-16)'($urandom);
      if ($urandom_range(0, 29) == 0) c[FLEN-1:16] = (FLEN-16)'($urandom);
      if ($urandom_range(0, 5) == 0) c = bx(rhalf() ^ 16'h0001);
      frm = 3'($urandom_range(0, 4));
      if (r < 5) rm = 3'(r);
      else if (r < 8) rm = 3'd7;
      else if (r == 8) begin rm = 3'd7; frm = 3'($urandom_range(0, 7)); end
      else begin rm = 3'($urandom_range(0, 7)); frm = 3'($urandom_range(0, 7)); end
      send(a, b, c, 2'($urandom_range(0, 3)), rm, frm, "R4");
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle(); idle(); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule